// File: doc/BRIEF.md
# Pulse Tone Voice with Sweep, Envelope and Length Timer

This block produces one rectangular tone as a 4-bit digital amplitude. An 8-step duty sequencer sets the shape of the tone. A period down-counter sets its pitch from an 11-bit frequency code `x`: the sequencer takes one step every `(2048 - x) * 4` system clocks. Three slow frame enables shape the sound over time. The 128 Hz enable drives a shift-and-add frequency sweep. The 64 Hz enable steps a saturating volume envelope. The 256 Hz enable counts down an optional play-time limit.

Software programs the voice through five byte-wide registers: sweep, duty/length, envelope, frequency low, and frequency high/control. A write with bit 7 set to the control register starts or restarts the tone. The block has no mixing, panning, master volume or conversion to analogue.

The control core is a two-state machine. `CH_SILENT` holds the amplitude at zero. `CH_SOUNDING` plays the tone. The transitions are:

- **TRIGGER**: from either state into `CH_SOUNDING`.
- **LEN_EXPIRE**: from `CH_SOUNDING` into `CH_SILENT`, when the length counter runs out with the length limit enabled.
- **SWEEP_OVERFLOW**: from `CH_SOUNDING` into `CH_SILENT`, when an additive sweep step would exceed 2047.

If none of these occur, the state is held.

Top module: `pulse_voice`

## Requirements
- R1: After reset the voice is silent (`active`=0, `amp`=0). The readback values are: sweep 0x80, duty/length 0xBF, envelope 0x00, frequency low 0xFF, control 0xBF.
- R2: The register indices are 0 sweep, 1 duty/length, 2 envelope, 3 frequency low, 4 control. The readback rules are:
  - Sweep reads `{1, bits 6:0}`.
  - Duty/length reads the duty in bits 7:6, with bits 5:0 as 1.
  - Envelope reads back in full.
  - Frequency low reads 0xFF.
  - Control reads bit 6 only, with all other bits as 1.
- R3: The duty code sits in bits 7:6 of register 1. With step `s` in 0..7, the output is high when:
  - code 00: s=7;
  - code 01: s>=6;
  - code 10: s>=4;
  - code 11: s>=2.

  When high, `amp` equals the envelope volume.
- R4: `x` is formed as `{control bits 2:0, frequency low}`. The step advances every `(2048-x)*4` clocks, counted from the trigger edge.
- R5: Writing register 4 with bit 7 set does all of the following:
  - enters `CH_SOUNDING`;
  - resets the step to 0;
  - loads the volume from the envelope's bits 7:4;
  - reloads the sweep timer, the envelope timer and the length counter (64 - t1, where t1 is register 1 bits 5:0).
- R6: With control bit 6 set, the voice goes silent on the (64 - t1)-th 256 Hz enable after the trigger.
- R7: With control bit 6 clear, the 256 Hz enables never silence the voice.
- R8: The envelope register holds the initial volume in bits 7:4, the direction in bit 3 (1 = up) and the step count n in bits 2:0. On every n-th 64 Hz enable the volume moves by one.
- R9: The volume never wraps: it stays at 15 going up and at 0 going down. With n = 0 it does not change.
- R10: The sweep register holds the sweep time T in bits 6:4, the direction in bit 3 (1 = subtract) and the shift k in bits 2:0. On every T-th 128 Hz enable, x becomes `x ± (x >> k)`. With T = 0 there is no change.
- R11: An additive sweep result above 2047 silences the voice and leaves x unchanged.
- R12: In `CH_SILENT` the amplitude is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Index of the register written |
| reg_wdata | input | 8 | Write data |
| reg_rsel | input | 3 | Index of the register read |
| reg_rdata | output | 8 | Readback data (combinational) |
| tick_len | input | 1 | 256 Hz frame enable, one clock wide |
| tick_sweep | input | 1 | 128 Hz frame enable, one clock wide |
| tick_env | input | 1 | 64 Hz frame enable, one clock wide |
| amp | output | 4 | Digital amplitude |
| active | output | 1 | High while the voice is sounding |

## Verification
The assertions check the following on every cycle:
- The duty step holds between counter expiries.
- A trigger resets the step.
- The volume saturates at both ends and is frozen when n = 0.
- The sweep shadow does not move when the sweep is off.
- Length expiry and sweep overflow both lead to `CH_SILENT`.
- Continuous mode stays in `CH_SOUNDING`.

Only the directed scenarios can show the cycle-exact values. These are the duty fractions, the exact period length, the step timing of the envelope, the arithmetic result of a sweep as seen in the length of a high phase, and the register readback masks.

// File: rtl/pulse_voice_pkg.sv
package pulse_voice_pkg;

    localparam int DUTY_STEPS = 8;
    localparam int STEP_W     = $clog2(DUTY_STEPS);

    typedef enum logic [0:0] {
        CH_SILENT   = 1'b0,
        CH_SOUNDING = 1'b1
    } ch_state_e;

    localparam logic [2:0] REG_SWEEP    = 3'd0;
    localparam logic [2:0] REG_DUTY_LEN = 3'd1;
    localparam logic [2:0] REG_ENV      = 3'd2;
    localparam logic [2:0] REG_FLO      = 3'd3;
    localparam logic [2:0] REG_FHI      = 3'd4;

    // High part of the 8-step pulse for each duty code.
    function automatic logic duty_high(input logic [1:0] duty, input logic [STEP_W-1:0] step);
        logic hi;
        unique case (duty)
            2'b00:   hi = (step == 3'd7);
            2'b01:   hi = (step >= 3'd6);
            2'b10:   hi = (step >= 3'd4);
            default: hi = (step >= 3'd2);
        endcase
        return hi;
    endfunction

endpackage

// File: rtl/pv_pulse_seq.sv
module pv_pulse_seq
    import pulse_voice_pkg::*;
#(
    parameter int FREQ_W       = 11,
    parameter int CLK_PER_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              trig,
    input  logic [FREQ_W-1:0] x_trig,
    input  logic [FREQ_W-1:0] x_cur,
    input  logic [1:0]        duty,
    output logic              wave_high
);
    localparam int PER_W = FREQ_W + $clog2(CLK_PER_STEP) + 1;
    localparam int FULL  = 1 << FREQ_W;

    logic [PER_W-1:0]  cnt_q;
    logic [STEP_W-1:0] step_q;

    function automatic logic [PER_W-1:0] period_of(input logic [FREQ_W-1:0] x);
        logic [PER_W-1:0] span;
        span = PER_W'(FULL) - PER_W'(x);
        return span * PER_W'(CLK_PER_STEP);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= period_of('0);
            step_q <= '0;
        end else if (trig) begin
            cnt_q  <= period_of(x_trig);
            step_q <= '0;
        end else if (run) begin
            if (cnt_q <= PER_W'(1)) begin
                cnt_q  <= period_of(x_cur);
                step_q <= step_q + 1'b1;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb wave_high = duty_high(duty, step_q);

    // R4: the step only moves when the period counter expires
    p_step_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !(run && cnt_q <= PER_W'(1))) |=> $stable(step_q));
    // R5: a trigger restarts the sequence at step 0
    p_step_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (step_q == '0));

endmodule

// File: rtl/pv_envelope.sv
module pv_envelope #(
    parameter int VOL_W = 4,
    parameter int ENV_N_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig,
    input  logic               tick,
    input  logic [VOL_W-1:0]   init_vol,
    input  logic               dir_up,
    input  logic [ENV_N_W-1:0] step_n,
    output logic [VOL_W-1:0]   vol
);
    localparam logic [VOL_W-1:0] VOL_MAX = '1;

    logic [ENV_N_W-1:0] timer_q;
    logic [VOL_W-1:0]   vol_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
            vol_q   <= '0;
        end else if (trig) begin
            timer_q <= step_n;
            vol_q   <= init_vol;
        end else if (tick && step_n != '0) begin
            if (timer_q <= ENV_N_W'(1)) begin
                timer_q <= step_n;
                if (dir_up && vol_q != VOL_MAX)
                    vol_q <= vol_q + 1'b1;
                else if (!dir_up && vol_q != '0)
                    vol_q <= vol_q - 1'b1;
            end else begin
                timer_q <= timer_q - 1'b1;
            end
        end
    end

    always_comb vol = vol_q;

    // R9: saturation at the top
    p_env_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && tick && dir_up && vol_q == VOL_MAX) |=> (vol_q == VOL_MAX));
    // R9: saturation at the bottom
    p_env_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && tick && !dir_up && vol_q == '0) |=> (vol_q == '0));
    // R9: a zero step count freezes the volume
    p_env_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && step_n == '0) |=> $stable(vol_q));

endmodule

// File: rtl/pv_sweep.sv
module pv_sweep #(
    parameter int FREQ_W = 11,
    parameter int SW_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              tick,
    input  logic [FREQ_W-1:0] x_trig,
    input  logic [SW_W-1:0]   sw_time,
    input  logic              sw_sub,
    input  logic [SW_W-1:0]   sw_shift,
    output logic              upd,
    output logic              ovf,
    output logic [FREQ_W-1:0] x_new
);
    logic [FREQ_W-1:0] shadow_q;
    logic [SW_W-1:0]   timer_q;
    logic [FREQ_W-1:0] delta;
    logic [FREQ_W:0]   sum;
    logic              fire;

    always_comb begin
        delta = shadow_q >> sw_shift;
        sum   = {1'b0, shadow_q} + {1'b0, delta};
        fire  = tick && !trig && (sw_time != '0) && (timer_q <= SW_W'(1));
        ovf   = fire && !sw_sub && sum[FREQ_W];
        upd   = fire && !ovf;
        x_new = sw_sub ? (shadow_q - delta) : sum[FREQ_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            timer_q  <= '0;
        end else if (trig) begin
            shadow_q <= x_trig;
            timer_q  <= sw_time;
        end else if (tick && sw_time != '0) begin
            if (fire) begin
                timer_q <= sw_time;
                if (upd) shadow_q <= x_new;
            end else begin
                timer_q <= timer_q - 1'b1;
            end
        end
    end

    // R10: with the sweep time at zero the frequency shadow is left alone
    p_sweep_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && sw_time == '0) |=> $stable(shadow_q));
    // R11: an overflowing step never lands in the shadow
    p_sweep_ovf_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> $stable(shadow_q));

endmodule

// File: rtl/pulse_voice.sv
module pulse_voice
    import pulse_voice_pkg::*;
#(
    parameter int FREQ_W       = 11,
    parameter int VOL_W        = 4,
    parameter int LEN_W        = 6,
    parameter int CLK_PER_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_sel,
    input  logic [7:0]       reg_wdata,
    input  logic [2:0]       reg_rsel,
    output logic [7:0]       reg_rdata,
    input  logic             tick_len,
    input  logic             tick_sweep,
    input  logic             tick_env,
    output logic [VOL_W-1:0] amp,
    output logic             active
);
    localparam int HI_W     = FREQ_W - 8;
    localparam int LCNT_W   = LEN_W + 1;
    localparam int LEN_FULL = 1 << LEN_W;
    localparam int SW_W     = 3;

    ch_state_e state_q, state_d;

    logic [SW_W-1:0]  sw_time_q, sw_shift_q;
    logic             sw_sub_q;
    logic [1:0]       duty_q;
    logic [LEN_W-1:0] t1_q;
    logic [7:0]       env_q;
    logic [7:0]       flo_q;
    logic [HI_W-1:0]  fhi_q;
    logic             len_en_q;
    logic [LCNT_W-1:0] len_cnt_q;

    logic              trig, sounding, len_expire;
    logic [FREQ_W-1:0] freq_q, x_trig, sw_x_new;
    logic              sw_upd, sw_ovf, wave_high;
    logic [VOL_W-1:0]  vol;

    always_comb begin
        trig       = reg_wr && (reg_sel == REG_FHI) && reg_wdata[7];
        sounding   = (state_q == CH_SOUNDING);
        freq_q     = {fhi_q, flo_q};
        x_trig     = {reg_wdata[HI_W-1:0], flo_q};
        len_expire = sounding && len_en_q && tick_len && (len_cnt_q == LCNT_W'(1));
    end

    // Register file; a software write wins over a sweep update in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_time_q  <= '0;
            sw_sub_q   <= 1'b0;
            sw_shift_q <= '0;
            duty_q     <= 2'b10;
            t1_q       <= '0;
            env_q      <= '0;
            flo_q      <= '0;
            fhi_q      <= '0;
            len_en_q   <= 1'b0;
        end else begin
            if (sw_upd) {fhi_q, flo_q} <= sw_x_new;
            if (reg_wr) begin
                case (reg_sel)
                    REG_SWEEP: begin
                        sw_time_q  <= reg_wdata[6:4];
                        sw_sub_q   <= reg_wdata[3];
                        sw_shift_q <= reg_wdata[2:0];
                    end
                    REG_DUTY_LEN: begin
                        duty_q <= reg_wdata[7:6];
                        t1_q   <= reg_wdata[LEN_W-1:0];
                    end
                    REG_ENV: env_q <= reg_wdata;
                    REG_FLO: flo_q <= reg_wdata;
                    REG_FHI: begin
                        fhi_q    <= reg_wdata[HI_W-1:0];
                        len_en_q <= reg_wdata[6];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_rsel)
            REG_SWEEP:    reg_rdata = {1'b1, sw_time_q, sw_sub_q, sw_shift_q};
            REG_DUTY_LEN: reg_rdata = {duty_q, 6'h3F};
            REG_ENV:      reg_rdata = env_q;
            REG_FLO:      reg_rdata = 8'hFF;
            REG_FHI:      reg_rdata = {1'b1, len_en_q, 6'h3F};
            default:      reg_rdata = 8'hFF;
        endcase
    end

    // Length counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_cnt_q <= '0;
        else if (trig)
            len_cnt_q <= LCNT_W'(LEN_FULL) - LCNT_W'(t1_q);
        else if (sounding && tick_len && len_en_q && len_cnt_q != '0)
            len_cnt_q <= len_cnt_q - 1'b1;
    end

    // Channel state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_SILENT;
        else        state_q <= state_d;
    end

    // Channel state machine: transitions TRIGGER, LEN_EXPIRE, SWEEP_OVERFLOW
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_SILENT:   if (trig) state_d = CH_SOUNDING;
            CH_SOUNDING: begin
                if (trig)                         state_d = CH_SOUNDING;
                else if (sw_ovf || len_expire)    state_d = CH_SILENT;
            end
            default:     state_d = CH_SILENT;
        endcase
    end

    // Channel state machine: outputs
    always_comb begin
        active = (state_q == CH_SOUNDING);
        amp    = (active && wave_high) ? vol : '0;
    end

    pv_pulse_seq #(.FREQ_W(FREQ_W), .CLK_PER_STEP(CLK_PER_STEP)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(sounding), .trig(trig),
        .x_trig(x_trig), .x_cur(freq_q), .duty(duty_q), .wave_high(wave_high)
    );

    pv_envelope #(.VOL_W(VOL_W), .ENV_N_W(3)) u_env (
        .clk(clk), .rst_n(rst_n), .trig(trig), .tick(tick_env && sounding),
        .init_vol(env_q[7:8-VOL_W]), .dir_up(env_q[3]), .step_n(env_q[2:0]), .vol(vol)
    );

    pv_sweep #(.FREQ_W(FREQ_W), .SW_W(SW_W)) u_sweep (
        .clk(clk), .rst_n(rst_n), .trig(trig), .tick(tick_sweep && sounding),
        .x_trig(x_trig), .sw_time(sw_time_q), .sw_sub(sw_sub_q), .sw_shift(sw_shift_q),
        .upd(sw_upd), .ovf(sw_ovf), .x_new(sw_x_new)
    );

    // R6: the last length tick silences the voice
    p_len_expire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (len_expire && !trig) |=> (state_q == CH_SILENT));
    // R7: without the length limit, only a sweep overflow ends the tone
    p_cont_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sounding && !len_en_q && !sw_ovf) |=> (state_q == CH_SOUNDING));
    // R11: a sweep overflow silences the voice
    p_ovf_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_ovf && !trig) |=> !active);

endmodule

// File: tb/pulse_voice_test.sv
module pulse_voice_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_sel = '0;
    logic [7:0] reg_wdata = '0;
    logic [2:0] reg_rsel = '0;
    logic [7:0] reg_rdata;
    logic       tick_len = 1'b0, tick_sweep = 1'b0, tick_env = 1'b0;
    logic [3:0] amp;
    logic       active;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pulse_voice uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
        .tick_len(tick_len), .tick_sweep(tick_sweep), .tick_env(tick_env),
        .amp(amp), .active(active)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog (R1..): got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output int v);
        reg_rsel = s;
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) tick_len = 1'b1;
        else if (which == 1) tick_sweep = 1'b1;
        else tick_env = 1'b1;
        @(negedge clk);
        tick_len = 1'b0; tick_sweep = 1'b0; tick_env = 1'b0;
    endtask

    task automatic trigger(input int x, input bit len_en);
        wr(3'd3, 8'(x));
        wr(3'd4, {1'b1, len_en, 3'b000, 3'(x >> 8)});
    endtask

    // Samples n negedges starting right after the trigger edge.
    task automatic sample(input int n, output int highs, output int first, output int peak);
        highs = 0; first = -1; peak = 0;
        for (int k = 0; k < n; k++) begin
            if (amp != 0) begin
                highs++;
                if (first < 0) first = k;
            end
            if (int'(amp) > peak) peak = int'(amp);
            @(negedge clk);
        end
    endtask

    task automatic level(output int peak);
        int h, f;
        sample(32, h, f, peak);
    endtask

    task automatic high_run(output int n);
        int guard = 0;
        n = 0;
        while (amp == 0 && guard < 40000) begin @(negedge clk); guard++; end
        while (amp != 0 && n < 40000) begin n++; @(negedge clk); end
    endtask

    function automatic int run_of(input int x);
        return 4 * (2048 - x) * 4;
    endfunction

    task automatic t_reset();
        int v;
        chk("R1 active", int'(active), 0);
        chk("R1 amp", int'(amp), 0);
        rd(3'd0, v); chk("R1 sweep rd", v, 8'h80);
        rd(3'd1, v); chk("R1 duty rd", v, 8'hBF);
        rd(3'd2, v); chk("R1 env rd", v, 8'h00);
        rd(3'd3, v); chk("R1 flo rd", v, 8'hFF);
        rd(3'd4, v); chk("R1 ctl rd", v, 8'hBF);
    endtask

    task automatic t_readback();
        int v;
        wr(3'd0, 8'h35); rd(3'd0, v); chk("R2 sweep rd", v, 8'hB5);
        wr(3'd1, 8'h40); rd(3'd1, v); chk("R2 duty rd", v, 8'h7F);
        wr(3'd2, 8'hA3); rd(3'd2, v); chk("R2 env rd", v, 8'hA3);
        wr(3'd3, 8'h12); rd(3'd3, v); chk("R2 flo rd", v, 8'hFF);
        wr(3'd4, 8'h47); rd(3'd4, v); chk("R2 ctl rd b6", v, 8'hFF);
        wr(3'd4, 8'h07); rd(3'd4, v); chk("R2 ctl rd", v, 8'hBF);
        chk("R2 no trigger without bit7", int'(active), 0);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_duty();
        int h, f, p;
        int exp_h[4] = '{4, 8, 16, 24};
        wr(3'd2, 8'hA0);
        for (int d = 0; d < 4; d++) begin
            wr(3'd1, {2'(d), 6'h00});
            trigger(2047, 1'b0);
            chk("R5 active after trigger", int'(active), 1);
            sample(32, h, f, p);
            chk($sformatf("R3 duty %0d high count", d), h, exp_h[d]);
            chk($sformatf("R3 duty %0d first high", d), f, 32 - exp_h[d]);
            chk($sformatf("R3 duty %0d amp=volume", d), p, 10);
        end
    endtask

    task automatic t_period();
        int h, f, p;
        wr(3'd1, 8'h80);
        trigger(2046, 1'b0);
        sample(64, h, f, p);
        chk("R4 period 8 first high", f, 32);
        chk("R4 period 8 high count", h, 32);
    endtask

    task automatic t_envelope();
        int p;
        wr(3'd1, 8'hC0);
        wr(3'd2, 8'h59);
        trigger(2047, 1'b0);
        level(p); chk("R5 initial volume", p, 5);
        pulse(2); level(p); chk("R8 up one step", p, 6);
        for (int i = 0; i < 10; i++) pulse(2);
        level(p); chk("R9 saturate at 15", p, 15);
        wr(3'd2, 8'h21);
        trigger(2047, 1'b0);
        for (int i = 0; i < 3; i++) pulse(2);
        level(p); chk("R9 saturate at 0", p, 0);
        chk("R9 still active at 0", int'(active), 1);
        wr(3'd2, 8'h82);
        trigger(2047, 1'b0);
        pulse(2); level(p); chk("R8 n=2 first tick holds", p, 8);
        pulse(2); level(p); chk("R8 n=2 second tick steps", p, 7);
        wr(3'd2, 8'h48);
        trigger(2047, 1'b0);
        for (int i = 0; i < 3; i++) pulse(2);
        level(p); chk("R9 n=0 frozen", p, 4);
    endtask

    task automatic t_length();
        int p;
        wr(3'd2, 8'hF0);
        wr(3'd1, 8'hBE);
        trigger(2047, 1'b1);
        pulse(0); chk("R6 t1=62 after 1 tick", int'(active), 1);
        pulse(0); chk("R6 t1=62 after 2 ticks", int'(active), 0);
        level(p); chk("R12 silent amp", p, 0);
        wr(3'd1, 8'h80);
        trigger(2047, 1'b1);
        chk("R5 retrigger after expiry", int'(active), 1);
        for (int i = 0; i < 63; i++) pulse(0);
        chk("R6 t1=0 after 63 ticks", int'(active), 1);
        pulse(0); chk("R6 t1=0 after 64 ticks", int'(active), 0);
        trigger(2047, 1'b0);
        for (int i = 0; i < 70; i++) pulse(0);
        chk("R7 continuous after 70 ticks", int'(active), 1);
    endtask

    task automatic t_sweep();
        int n, p;
        wr(3'd1, 8'h80);
        wr(3'd2, 8'hF0);
        wr(3'd0, 8'h13);
        trigger(1800, 1'b0);
        pulse(1);
        high_run(n); chk("R10 add shift3 run", n, run_of(1800 + (1800 >> 3)));
        wr(3'd0, 8'h1B);
        trigger(1800, 1'b0);
        pulse(1);
        high_run(n); chk("R10 sub shift3 run", n, run_of(1800 - (1800 >> 3)));
        wr(3'd0, 8'h03);
        trigger(1800, 1'b0);
        pulse(1);
        high_run(n); chk("R10 sweep off run", n, run_of(1800));
        wr(3'd0, 8'h10);
        trigger(1800, 1'b0);
        pulse(1);
        chk("R11 overflow silences", int'(active), 0);
        level(p); chk("R12 amp after overflow", p, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_duty();
        t_period();
        t_envelope();
        t_length();
        t_sweep();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule